// File: doc/BRIEF.md
# Sector Erase Batch Window Timer

This block sits on the device side of a flash controller. It gathers sector erase requests into one batch and reports the progress of that batch on a single status bit. The first valid sector erase command opens an acceptance window. Each further sector erase command that arrives while the window is open adds its sector to the batch and starts the full window again. When the window runs out, the status bit goes high, a one-cycle start pulse tells the erase engine to begin, and the selection mask is held until the engine reports completion.

A chip erase command received while idle does not open a window. It selects every sector and starts at once. While an erase is running, every command except erase suspend is dropped and flagged on a one-cycle ignored pulse. Suspend is only taken in. Pausing the erase belongs to the engine. The window length is a parameter in clock cycles. Its default of 12500 cycles equals 50 µs at a 250 MHz clock.

Top module: `ewin_sector_erase_timer`

## Requirements
- R1: After reset, sect_mask is 0 and dq3_status, erase_start and cmd_ignored are all 0.
- R2: In idle, a sector erase strobe with an index below NUM_SECTORS sets bit idx of sect_mask (bit i selects sector i) in the next cycle. dq3_status stays 0 while the window is open.
- R3: dq3_status rises exactly WINDOW_CYCLES cycles after the clock edge that took the last accepted sector command, with a default of 12500 cycles (50 µs at 250 MHz). erase_start is high for exactly that one cycle.
- R4: While the window is open, each valid sector erase strobe adds its bit to sect_mask and restarts the full WINDOW_CYCLES window.
- R5: A command of any kind other than suspend that is sampled in the same cycle the window expires is not added to the batch. It gives a cmd_ignored pulse in the next cycle.
- R6: While erasing (dq3_status = 1), a sector erase, chip erase or other-command strobe gives a one-cycle cmd_ignored pulse and leaves sect_mask unchanged. suspend_vld never gives cmd_ignored. In any cycle where suspend_vld is high, the other strobes of that cycle are disregarded.
- R7: erase_done sampled while erasing gives dq3_status = 0 and sect_mask = 0 in the next cycle.
- R8: A chip erase strobe in idle gives, in the next cycle, dq3_status = 1, a one-cycle erase_start and all ones on sect_mask. No window is opened.
- R9: While the window is open, chip erase and other-command strobes give cmd_ignored and change neither sect_mask nor the expiry cycle.
- R10: A sector erase strobe with an index of NUM_SECTORS or more gives cmd_ignored and leaves the block in its current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sect_erase_vld | input | 1 | Sector erase command strobe |
| sect_erase_idx | input | IDX_W | Sector index for the sector erase strobe |
| chip_erase_vld | input | 1 | Chip erase command strobe |
| suspend_vld | input | 1 | Erase suspend command strobe |
| other_cmd_vld | input | 1 | Strobe for any other command |
| erase_done | input | 1 | Erase engine completion |
| sect_mask | output | NUM_SECTORS | Selected sectors of the batch |
| dq3_status | output | 1 | 0 while idle or collecting, 1 while erasing |
| erase_start | output | 1 | One-cycle pulse when the erase begins |
| cmd_ignored | output | 1 | One-cycle pulse for a dropped command |

## Verification
Two events can fall in the same cycle: the window running out and a new sector command arriving. The bench counts exactly WINDOW_CYCLES-1 cycles after an accepted command, then drives a second sector strobe so that it is sampled on the expiry edge. The result must show the start pulse and the ignored pulse together, with the late sector missing from the mask. A command sampled in the same cycle as erase_done is used the same way. It must be flagged as ignored while the block returns to idle.

// File: rtl/ewin_pkg.sv
package ewin_pkg;
  typedef enum logic [1:0] {
    EW_IDLE    = 2'd0,
    EW_COLLECT = 2'd1,
    EW_ERASING = 2'd2
  } ew_state_e;
endpackage

// File: rtl/ewin_window_timer.sv
module ewin_window_timer #(
  parameter int WINDOW_CYCLES = 12500,
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic load,
  output logic expire
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WINDOW_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = RELOAD;
    end else if (run && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = run && (cnt_q == '0);
endmodule

// File: rtl/ewin_sector_batch.sv
module ewin_sector_batch #(
  parameter int NUM_SECTORS = 11,
  localparam int IDX_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_en,
  input  logic [IDX_W-1:0]       set_idx,
  input  logic                   set_all,
  input  logic                   clr,
  output logic [NUM_SECTORS-1:0] mask
);
  logic [NUM_SECTORS-1:0] mask_q;

  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
    logic bit_d, bit_en;
    always_comb begin
      bit_en = clr || set_all || (set_en && (set_idx == IDX_W'(i)));
      bit_d  = !clr;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q[i] <= 1'b0;
      else if (bit_en) mask_q[i] <= bit_d;
    end
  end

  assign mask = mask_q;
endmodule

// File: rtl/ewin_ctrl.sv
module ewin_ctrl
  import ewin_pkg::*;
#(
  parameter int NUM_SECTORS = 11,
  localparam int IDX_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sect_vld,
  input  logic [IDX_W-1:0] sect_idx,
  input  logic             chip_vld,
  input  logic             susp_vld,
  input  logic             other_vld,
  input  logic             done,
  input  logic             expire,
  output ew_state_e        state,
  output logic             timer_load,
  output logic             mask_set,
  output logic             mask_all,
  output logic             mask_clr,
  output logic             start_pulse,
  output logic             ign_pulse
);
  ew_state_e state_q, state_d;
  logic      start_q, start_d;
  logic      ign_q, ign_d;
  logic      s_vld, c_vld, o_vld, idx_ok, any_cmd;

  // a suspend in the same cycle masks every other strobe
  always_comb begin
    s_vld   = sect_vld  && !susp_vld;
    c_vld   = chip_vld  && !susp_vld;
    o_vld   = other_vld && !susp_vld;
    idx_ok  = 32'(sect_idx) < NUM_SECTORS;
    any_cmd = s_vld || c_vld || o_vld;
  end

  always_comb begin
    state_d    = state_q;
    start_d    = 1'b0;
    ign_d      = 1'b0;
    timer_load = 1'b0;
    mask_set   = 1'b0;
    mask_all   = 1'b0;
    mask_clr   = 1'b0;
    unique case (state_q)
      EW_IDLE: begin
        if (c_vld) begin
          state_d  = EW_ERASING;
          start_d  = 1'b1;
          mask_all = 1'b1;
        end else if (s_vld) begin
          if (idx_ok) begin
            state_d    = EW_COLLECT;
            timer_load = 1'b1;
            mask_set   = 1'b1;
          end else begin
            ign_d = 1'b1;
          end
        end
      end
      EW_COLLECT: begin
        if (expire) begin
          state_d = EW_ERASING;
          start_d = 1'b1;
          ign_d   = any_cmd;
        end else if (s_vld && idx_ok) begin
          timer_load = 1'b1;
          mask_set   = 1'b1;
        end else begin
          ign_d = any_cmd;
        end
      end
      EW_ERASING: begin
        ign_d = any_cmd;
        if (done) begin
          state_d  = EW_IDLE;
          mask_clr = 1'b1;
        end
      end
      default: state_d = EW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EW_IDLE;
      start_q <= 1'b0;
      ign_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      ign_q   <= ign_d;
    end
  end

  assign state       = state_q;
  assign start_pulse = start_q;
  assign ign_pulse   = ign_q;
endmodule

// File: rtl/ewin_sector_erase_timer.sv
module ewin_sector_erase_timer
  import ewin_pkg::*;
#(
  parameter int NUM_SECTORS   = 11,
  parameter int WINDOW_CYCLES = 12500,
  localparam int IDX_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sect_erase_vld,
  input  logic [IDX_W-1:0]       sect_erase_idx,
  input  logic                   chip_erase_vld,
  input  logic                   suspend_vld,
  input  logic                   other_cmd_vld,
  input  logic                   erase_done,
  output logic [NUM_SECTORS-1:0] sect_mask,
  output logic                   dq3_status,
  output logic                   erase_start,
  output logic                   cmd_ignored
);
  ew_state_e state;
  logic      expire, timer_load, mask_set, mask_all, mask_clr;

  ewin_ctrl #(.NUM_SECTORS(NUM_SECTORS)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sect_vld   (sect_erase_vld),
    .sect_idx   (sect_erase_idx),
    .chip_vld   (chip_erase_vld),
    .susp_vld   (suspend_vld),
    .other_vld  (other_cmd_vld),
    .done       (erase_done),
    .expire     (expire),
    .state      (state),
    .timer_load (timer_load),
    .mask_set   (mask_set),
    .mask_all   (mask_all),
    .mask_clr   (mask_clr),
    .start_pulse(erase_start),
    .ign_pulse  (cmd_ignored)
  );

  ewin_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == EW_COLLECT),
    .load  (timer_load),
    .expire(expire)
  );

  ewin_sector_batch #(.NUM_SECTORS(NUM_SECTORS)) batch_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (mask_set),
    .set_idx(sect_erase_idx),
    .set_all(mask_all),
    .clr    (mask_clr),
    .mask   (sect_mask)
  );

  assign dq3_status = (state == EW_ERASING);
endmodule

// File: rtl/ewin_chk.sv
module ewin_chk #(
  parameter int NUM_SECTORS = 11
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sect_erase_vld,
  input logic                   chip_erase_vld,
  input logic                   suspend_vld,
  input logic                   other_cmd_vld,
  input logic                   erase_done,
  input logic [NUM_SECTORS-1:0] sect_mask,
  input logic                   dq3_status,
  input logic                   erase_start,
  input logic                   cmd_ignored
);
  // R3
  start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  // R3
  dq3_rise_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq3_status) |-> erase_start);

  // R7
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq3_status && erase_done) |=> (!dq3_status && (sect_mask == '0)));

  // R6
  erasing_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq3_status && !erase_done) |=> $stable(sect_mask));

  // R6
  erasing_drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq3_status && !suspend_vld && (sect_erase_vld || chip_erase_vld || other_cmd_vld))
      |=> cmd_ignored);

  // R6
  suspend_never_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_vld |=> !cmd_ignored);

  // R8
  chip_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dq3_status && (sect_mask == '0) && chip_erase_vld && !suspend_vld)
      |=> (dq3_status && erase_start && (&sect_mask)));
endmodule

bind ewin_sector_erase_timer ewin_chk #(.NUM_SECTORS(NUM_SECTORS)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .sect_erase_vld(sect_erase_vld),
  .chip_erase_vld(chip_erase_vld),
  .suspend_vld   (suspend_vld),
  .other_cmd_vld (other_cmd_vld),
  .erase_done    (erase_done),
  .sect_mask     (sect_mask),
  .dq3_status    (dq3_status),
  .erase_start   (erase_start),
  .cmd_ignored   (cmd_ignored)
);

// File: tb/ewin_sector_erase_timer_tb_top.sv
`timescale 1ns/1ps
module ewin_sector_erase_timer_tb_top;
  localparam int NS  = 11;
  localparam int W   = 12500;
  localparam int IW  = $clog2(NS);
  localparam int ALL = (1 << NS) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sect_erase_vld, chip_erase_vld, suspend_vld, other_cmd_vld, erase_done;
  logic [IW-1:0] sect_erase_idx;
  logic [NS-1:0] sect_mask;
  logic          dq3_status, erase_start, cmd_ignored;

  int vectors = 0;
  int misses  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ewin_sector_erase_timer dut_i (
    .clk(clk), .rst_n(rst_n),
    .sect_erase_vld(sect_erase_vld), .sect_erase_idx(sect_erase_idx),
    .chip_erase_vld(chip_erase_vld), .suspend_vld(suspend_vld),
    .other_cmd_vld(other_cmd_vld), .erase_done(erase_done),
    .sect_mask(sect_mask), .dq3_status(dq3_status),
    .erase_start(erase_start), .cmd_ignored(cmd_ignored)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic issue_sector(input int idx);
    sect_erase_idx = IW'(idx);
    sect_erase_vld = 1'b1;
    @(negedge clk);
    sect_erase_vld = 1'b0;
  endtask

  task automatic issue_chip();
    chip_erase_vld = 1'b1; @(negedge clk); chip_erase_vld = 1'b0;
  endtask

  task automatic issue_other();
    other_cmd_vld = 1'b1; @(negedge clk); other_cmd_vld = 1'b0;
  endtask

  task automatic issue_suspend();
    suspend_vld = 1'b1; @(negedge clk); suspend_vld = 1'b0;
  endtask

  task automatic finish_erase();
    erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
    chk("R7 dq3 after done", dq3_status, 0);
    chk("R7 mask after done", sect_mask, 0);
  endtask

  task automatic t_reset();
    chk("R1 mask", sect_mask, 0);
    chk("R1 dq3", dq3_status, 0);
    chk("R1 start", erase_start, 0);
    chk("R1 ignored", cmd_ignored, 0);
  endtask

  task automatic t_single_window();
    issue_sector(0);
    chk("R2 mask bit0", sect_mask, 1);
    chk("R2 dq3 open", dq3_status, 0);
    wait_neg(W - 1);
    chk("R3 dq3 before expiry", dq3_status, 0);
    chk("R3 no start yet", erase_start, 0);
    wait_neg(1);
    chk("R3 dq3 at expiry", dq3_status, 1);
    chk("R3 start pulse", erase_start, 1);
    wait_neg(1);
    chk("R3 start one cycle", erase_start, 0);
    finish_erase();
  endtask

  task automatic t_restart();
    issue_sector(2);
    wait_neg(6000);
    issue_sector(5);
    chk("R4 mask add", sect_mask, 36);
    wait_neg(W - 1);
    chk("R4 window restarted", dq3_status, 0);
    wait_neg(1);
    chk("R4 expiry after restart", dq3_status, 1);
    chk("R4 start", erase_start, 1);
    chk("R4 mask held", sect_mask, 36);
    finish_erase();
  endtask

  task automatic t_expiry_collision();
    issue_sector(4);
    wait_neg(W - 1);
    issue_sector(6);
    chk("R5 dq3 rises", dq3_status, 1);
    chk("R5 start", erase_start, 1);
    chk("R5 ignored", cmd_ignored, 1);
    chk("R5 late sector not added", sect_mask, 16);
    finish_erase();
  endtask

  task automatic t_chip_and_erasing();
    issue_chip();
    chk("R8 dq3 immediate", dq3_status, 1);
    chk("R8 start", erase_start, 1);
    chk("R8 all sectors", sect_mask, ALL);
    issue_sector(3);
    chk("R6 sector ignored", cmd_ignored, 1);
    chk("R6 mask unchanged", sect_mask, ALL);
    issue_other();
    chk("R6 other ignored", cmd_ignored, 1);
    issue_suspend();
    chk("R6 suspend not flagged", cmd_ignored, 0);
    chk("R6 still erasing", dq3_status, 1);
    // a command sampled with erase_done
    erase_done = 1'b1; other_cmd_vld = 1'b1;
    @(negedge clk);
    erase_done = 1'b0; other_cmd_vld = 1'b0;
    chk("R6 ignored with done", cmd_ignored, 1);
    chk("R7 idle after done", dq3_status, 0);
    chk("R7 mask cleared", sect_mask, 0);
  endtask

  task automatic t_window_drops();
    issue_sector(1);
    wait_neg(100);
    issue_other();
    chk("R9 other ignored", cmd_ignored, 1);
    issue_chip();
    chk("R9 chip ignored", cmd_ignored, 1);
    chk("R9 mask unchanged", sect_mask, 2);
    chk("R9 no erase", dq3_status, 0);
    wait_neg(W - 1 - 102);
    chk("R9 expiry not moved (before)", dq3_status, 0);
    wait_neg(1);
    chk("R9 expiry not moved (at)", dq3_status, 1);
    finish_erase();
  endtask

  task automatic t_bad_index();
    issue_sector(13);
    chk("R10 ignored", cmd_ignored, 1);
    chk("R10 mask", sect_mask, 0);
    chk("R10 dq3", dq3_status, 0);
    wait_neg(1);
    chk("R10 pulse one cycle", cmd_ignored, 0);
    chk("R10 no start", erase_start, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    sect_erase_vld = 1'b0; sect_erase_idx = '0; chip_erase_vld = 1'b0;
    suspend_vld = 1'b0; other_cmd_vld = 1'b0; erase_done = 1'b0;
    wait_neg(4);
    rst_n = 1'b1;
    wait_neg(1);
    t_reset();
    t_bad_index();
    t_single_window();
    t_restart();
    t_expiry_collision();
    t_chip_and_erasing();
    t_window_drops();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule